// File: doc/BRIEF.md
# Runahead Speculative Store Cache

This block is a small, direct-mapped buffer that catches store data produced while a core runs ahead past a long-latency miss. Runahead stores land here and nowhere else, so the architectural memory hierarchy is never changed. Later runahead loads can then pick up values that earlier runahead stores made. A store whose address is not known is dropped. A store whose address is known but whose data is not known still claims its entry, and it marks that entry as holding poisoned data.

A load looks up this buffer in the same cycle as its L1 data-cache lookup. The block takes the L1 word as an input and returns one merged result. A hit here takes priority over the L1 word, and a miss passes the L1 word through unchanged. Each entry holds one word. A new store to an occupied index simply overwrites the older entry, and the older entry's contents are lost. When runahead ends, a single-cycle flush empties the whole buffer.

Top module: `rh_store_cache`

## Requirements
- R1: After reset every entry is empty, so any load returns ld_hit=0 and ld_invalid=0, with ld_data equal to l1_data.
- R2: When a store with st_en=1, st_addr_ok=1, st_data_ok=1 and flush=0 is accepted at a clock edge, any later load to the same word address returns ld_hit=1, ld_invalid=0 and the stored data. This holds until the entry is replaced or flushed.
- R3: A store with st_addr_ok=0 changes no entry. A later load returns the same results it would have returned without that store.
- R4: A store with st_addr_ok=1 and st_data_ok=0 allocates or updates its entry with the poison mark set. A later load to that address returns ld_hit=1 and ld_invalid=1, and ld_data is then unspecified.
- R5: On a miss, ld_hit=0, ld_invalid=0 and ld_data equals l1_data in the same cycle.
- R6: On a hit, ld_data comes from the buffer and the value on l1_data is ignored.
- R7: The entry index is the low IDX_W bits of the word address, and the tag is the remaining upper bits. A store to an occupied index with a different tag replaces the entry, and a load to the old address then misses.
- R8: A clock edge with flush=1 empties every entry at once. A store presented in that same cycle is discarded.
- R9: The lookup is combinational on the entry state. A load in the same cycle as a store to the same address sees the contents from before that store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the whole buffer at this edge (runahead exit) |
| st_en | input | 1 | Runahead store present |
| st_addr | input | AW | Store word address |
| st_addr_ok | input | 1 | Store address is known |
| st_data | input | DW | Store data |
| st_data_ok | input | 1 | Store data is known |
| ld_addr | input | AW | Load word address |
| l1_data | input | DW | Word read in parallel from the L1 data cache |
| ld_hit | output | 1 | Load matched a buffer entry |
| ld_data | output | DW | Merged load data |
| ld_invalid | output | 1 | Load result is poisoned |

## Verification
The assertions assume that reset is held low before the first edge. They also assume that the address inputs are always driven to known values, because the tag compare and the index selection read them in every cycle. The assertions relate a store at one edge to the lookup result for the same address in the next cycle, and a flush to an all-miss result in the next cycle. The bench changes inputs only on the falling edge, keeps every input at a defined 0 or 1, and draws addresses from a 32-word range so that index conflicts, replacements and same-cycle store/load pairs occur often.

// File: rtl/rh_store_cache.sv
module rh_store_cache #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int IDX_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          st_en,
  input  logic [AW-1:0] st_addr,
  input  logic          st_addr_ok,
  input  logic [DW-1:0] st_data,
  input  logic          st_data_ok,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] l1_data,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  output logic          ld_invalid
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TW    = AW - IDX_W;

  logic [DEPTH-1:0] vld, bad;
  logic [TW-1:0]    tag_q [DEPTH];
  logic [DW-1:0]    dat_q [DEPTH];

  wire [IDX_W-1:0] st_idx = st_addr[IDX_W-1:0];
  wire [TW-1:0]    st_tag = st_addr[AW-1:IDX_W];
  wire [IDX_W-1:0] ld_idx = ld_addr[IDX_W-1:0];
  wire [TW-1:0]    ld_tag = ld_addr[AW-1:IDX_W];
  wire             st_go  = st_en & st_addr_ok & ~flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      bad <= '0;
    end else if (flush) begin
      vld <= '0;
      bad <= '0;
    end else if (st_go) begin
      vld[st_idx] <= 1'b1;
      bad[st_idx] <= ~st_data_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (st_go) begin
      tag_q[st_idx] <= st_tag;
      dat_q[st_idx] <= st_data;
    end
  end

  assign ld_hit     = vld[ld_idx] && (tag_q[ld_idx] == ld_tag);
  assign ld_invalid = ld_hit & bad[ld_idx];
  assign ld_data    = ld_hit ? dat_q[ld_idx] : l1_data;

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !ld_hit);

  assert_store_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && st_addr_ok && st_data_ok && !flush) |=>
      (ld_addr != $past(st_addr)) || (ld_hit && !ld_invalid && ld_data == $past(st_data)));

  assert_poison_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && st_addr_ok && !st_data_ok && !flush) |=>
      (ld_addr != $past(st_addr)) || (ld_hit && ld_invalid));

  assert_unknown_addr_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && !st_addr_ok && !flush) |=> ($stable(vld) && $stable(bad)));

  assert_miss_passes_l1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ld_data == l1_data && !ld_invalid));
endmodule

// File: tb/test_rh_store_cache.sv
`timescale 1ns/1ps
module test_rh_store_cache;
  localparam int AW = 16, DW = 32, IDX_W = 3;
  localparam int DEPTH = 1 << IDX_W;
  localparam int TW = AW - IDX_W;

  logic clk = 0, rst_n = 0, flush = 0, st_en = 0, st_addr_ok = 0, st_data_ok = 0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [DW-1:0] st_data = '0, l1_data = '0;
  logic ld_hit, ld_invalid;
  logic [DW-1:0] ld_data;

  always #2.5 clk = ~clk;

  rh_store_cache #(.AW(AW), .DW(DW), .IDX_W(IDX_W)) i_rh_store_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush), .st_en(st_en), .st_addr(st_addr),
    .st_addr_ok(st_addr_ok), .st_data(st_data), .st_data_ok(st_data_ok),
    .ld_addr(ld_addr), .l1_data(l1_data), .ld_hit(ld_hit), .ld_data(ld_data),
    .ld_invalid(ld_invalid));

  int checks = 0, failures = 0;
  bit done = 0;
  logic          m_v   [DEPTH];
  logic          m_bad [DEPTH];
  logic [TW-1:0] m_tag [DEPTH];
  logic [DW-1:0] m_dat [DEPTH];

  function automatic bit exp_hit(input logic [AW-1:0] a);
    return m_v[a[IDX_W-1:0]] && (m_tag[a[IDX_W-1:0]] == a[AW-1:IDX_W]);
  endfunction

  function automatic logic [DW-1:0] exp_data(input logic [AW-1:0] a, input logic [DW-1:0] l1);
    return exp_hit(a) ? m_dat[a[IDX_W-1:0]] : l1;
  endfunction

  function automatic bit exp_inv(input logic [AW-1:0] a);
    return exp_hit(a) && m_bad[a[IDX_W-1:0]];
  endfunction

  task automatic step(input string req, input bit se, input logic [AW-1:0] sa, input bit sao,
                      input logic [DW-1:0] sd, input bit sdo, input bit fl,
                      input logic [AW-1:0] la, input logic [DW-1:0] l1);
    bit eh, ei;
    logic [DW-1:0] ed;
    st_en = se; st_addr = sa; st_addr_ok = sao; st_data = sd; st_data_ok = sdo;
    flush = fl; ld_addr = la; l1_data = l1;
    #1;
    eh = exp_hit(la); ei = exp_inv(la); ed = exp_data(la, l1);
    checks++;
    if (ld_hit !== eh || ld_invalid !== ei || (!ei && ld_data !== ed)) begin
      failures++;
      $display("FAIL %s addr=%h: hit=%b inv=%b data=%h expected hit=%b inv=%b data=%h",
               req, la, ld_hit, ld_invalid, ld_data, eh, ei, ed);
    end
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < DEPTH; i++) begin m_v[i] = 0; m_bad[i] = 0; end
    end else if (se && sao) begin
      m_v[sa[IDX_W-1:0]]   = 1;
      m_bad[sa[IDX_W-1:0]] = ~sdo;
      m_tag[sa[IDX_W-1:0]] = sa[AW-1:IDX_W];
      m_dat[sa[IDX_W-1:0]] = sd;
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < DEPTH; i++) begin m_v[i] = 0; m_bad[i] = 0; m_tag[i] = '0; m_dat[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 / R5: empty after reset, L1 passes through
    step("R1", 0, 0, 0, 0, 0, 0, 16'h0005, 32'h1111_2222);
    step("R5", 0, 0, 0, 0, 0, 0, 16'h0123, 32'hCAFE_0001);
    // R2 / R6: store then hit overrides L1
    step("R2", 1, 16'h0005, 1, 32'hAAAA_0005, 1, 0, 16'h0040, 32'h0);
    step("R6", 0, 0, 0, 0, 0, 0, 16'h0005, 32'hDEAD_BEEF);
    // R3: unknown address store dropped
    step("R3", 1, 16'h0005, 0, 32'hBBBB_BBBB, 1, 0, 16'h0005, 32'h9);
    step("R3", 0, 0, 0, 0, 0, 0, 16'h0005, 32'h9);
    step("R3", 1, 16'h0006, 0, 32'hBBBB_0006, 1, 0, 16'h0006, 32'h7);
    step("R3", 0, 0, 0, 0, 0, 0, 16'h0006, 32'h7);
    // R4: poisoned store
    step("R4", 1, 16'h0009, 1, 32'h0, 0, 0, 16'h0009, 32'h3);
    step("R4", 0, 0, 0, 0, 0, 0, 16'h0009, 32'h3);
    // R7: conflicting tag replaces entry
    step("R7", 1, 16'h000D, 1, 32'hCCCC_000D, 1, 0, 16'h0005, 32'h4);
    step("R7", 0, 0, 0, 0, 0, 0, 16'h0005, 32'h4444_0005);
    step("R7", 0, 0, 0, 0, 0, 0, 16'h000D, 32'h4);
    // R9: same-cycle store and load sees old contents
    step("R9", 1, 16'h0014, 1, 32'h9999_0014, 1, 0, 16'h0014, 32'h5555);
    step("R9", 0, 0, 0, 0, 0, 0, 16'h0014, 32'h5555);
    // R8: flush empties all, same-cycle store discarded
    step("R8", 1, 16'h0003, 1, 32'h3333_3333, 1, 1, 16'h000D, 32'h6);
    step("R8", 0, 0, 0, 0, 0, 0, 16'h000D, 32'h6);
    step("R8", 0, 0, 0, 0, 0, 0, 16'h0003, 32'h8);
    step("R8", 0, 0, 0, 0, 0, 0, 16'h0009, 32'h8);
    // random mix covering R2..R9
    for (int n = 0; n < 4000; n++) begin
      step("RND R2-mix", $urandom_range(0, 3) != 0, 16'($urandom_range(0, 31)),
           $urandom_range(0, 4) != 0, $urandom, $urandom_range(0, 5) != 0,
           $urandom_range(0, 60) == 0, 16'($urandom_range(0, 31)), $urandom);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule